// File: doc/BRIEF.md
# Oriented Frame Base Address Generator

This block turns the corner coordinates of a rectangular frame buffer into the byte address of the first pixel of that frame, as seen through one of eight orientation views of a large two-dimensional pixel container. A request gives the top-left and bottom-right corners in natural-orientation pixel units. It also gives three view bits and a pixel-size mode. The view bits are transpose (S), vertical mirror (Y) and horizontal mirror (X). The block answers with the first-pixel coordinates in the oriented view, a 29-bit in-view byte offset and a 33-bit full address that also encodes the view.

The container shape depends on the pixel size. 8-bit pixels form 8192 lines of 16384 pixels. 16-bit pixels form 4096 lines of 16384 pixels. 32-bit pixels form 4096 lines of 8192 pixels. Mirroring measures the frame from the far edge of the container. Transposing swaps which coordinate is scaled by the line length. The result comes out of a two-stage pipeline that accepts one request per cycle. Bad requests are flagged in place of a result.

Top module: `ofb_addr_gen`

## Requirements
- R1: The oriented x (xo) equals x0 when X=0 and W-1-x1 when X=1, where W is the container width for the selected mode.
- R2: The oriented y (yo) equals y0 when Y=0 and H-1-y1 when Y=1, where H is the container height for the selected mode.
- R3: With S=0, the byte part of the offset (bits 26:0) is (yo*W + xo) times the pixel size in bytes.
- R4: With S=1, the byte part of the offset is (xo*H + yo) times the pixel size in bytes.
- R5: Mode code 00 selects 1-byte pixels in a 16384x8192 container. Code 01 selects 2-byte pixels in 16384x4096. Code 10 selects 4-byte pixels in 8192x4096. Offset bits 28:27 carry the mode code, so they are zero in 8-bit mode.
- R6: The full address has bit 32 set, S in bit 31, Y in bit 30, X in bit 29, and the 29-bit offset in bits 28:0.
- R7: The reported first-pixel coordinates are (xo,yo) when S=0 and (yo,xo) when S=1.
- R8: Mode code 11 raises out_err and keeps out_valid low for that request.
- R9: A request with x1<x0, y1<y0, x1>=W or y1>=H raises out_err and keeps out_valid low.
- R10: Each request accepted with in_valid produces exactly one of out_valid or out_err two clock cycles later. No output strobe appears without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| in_mode | input | 2 | Pixel-size mode code |
| in_syx | input | 3 | View bits {S,Y,X} |
| in_x0 | input | 14 | Top-left x, natural orientation |
| in_y0 | input | 14 | Top-left y, natural orientation |
| in_x1 | input | 14 | Bottom-right x, natural orientation |
| in_y1 | input | 14 | Bottom-right y, natural orientation |
| out_valid | output | 1 | Result strobe for a good request |
| out_err | output | 1 | Strobe for a rejected request |
| out_x | output | 14 | First-pixel x in the oriented view |
| out_y | output | 14 | First-pixel y in the oriented view |
| out_offset | output | 29 | In-view byte offset with mode bits |
| out_addr | output | 33 | Full address with view bits |

## Verification
The assertions assume that in_valid is low during reset. They also assume that the mode and corner inputs are stable and known whenever in_valid is high. No assertion assumes the corners are legal, because rejection is a checked behaviour. The bench drives every request on a falling edge with defined values and pulses in_valid low during reset. Illegal corners and the unsupported mode are sent on purpose, so that the rejection paths run against the same properties as the good requests.

// File: rtl/ofb_pkg.sv
package ofb_pkg;

  typedef enum logic [1:0] {
    PIX8    = 2'b00,
    PIX16   = 2'b01,
    PIX32   = 2'b10,
    PIX_BAD = 2'b11
  } pix_mode_e;

  // log2 of the line length: only the 4-byte mode halves it
  function automatic logic [5:0] lg_width(input logic [1:0] m, input logic [5:0] base);
    return base - {5'd0, (m == PIX32)};
  endfunction

  // log2 of the line count: every mode wider than a byte halves it
  function automatic logic [5:0] lg_height(input logic [1:0] m, input logic [5:0] base);
    return base - {5'd0, (m != PIX8)};
  endfunction

  // distance of a far-edge coordinate from the opposite container edge
  function automatic logic [31:0] reflect(input logic [31:0] v, input logic [5:0] lg);
    return ((32'd1 << lg) - 32'd1) - v;
  endfunction

  // linear pixel index scaled to bytes; the multiply is a shift by a power of two
  function automatic logic [63:0] byte_index(input logic [31:0] major, input logic [31:0] minor,
                                             input logic [5:0] lg_line, input logic [1:0] m);
    logic [63:0] pix;
    pix = ({32'd0, major} << lg_line) + {32'd0, minor};
    return pix << m;
  endfunction

endpackage

// File: rtl/ofb_orient.sv
module ofb_orient #(
  parameter int CW     = 14,
  parameter int LOG_W8 = 14,
  parameter int LOG_H8 = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [1:0]    in_mode,
  input  logic [2:0]    in_syx,
  input  logic [CW-1:0] in_x0,
  input  logic [CW-1:0] in_y0,
  input  logic [CW-1:0] in_x1,
  input  logic [CW-1:0] in_y1,
  output logic          s1_valid,
  output logic          s1_err,
  output logic [2:0]    s1_syx,
  output logic [1:0]    s1_mode,
  output logic [CW-1:0] s1_xo,
  output logic [CW-1:0] s1_yo,
  output logic [CW-1:0] s1_major,
  output logic [CW-1:0] s1_minor,
  output logic [5:0]    s1_shift
);
  import ofb_pkg::*;

  logic [5:0]  lw, lh;
  logic [31:0] w_lim, h_lim, xo_c, yo_c;
  logic        bad_mode, bad_range;

  always_comb begin
    lw        = lg_width(in_mode, 6'(LOG_W8));
    lh        = lg_height(in_mode, 6'(LOG_H8));
    w_lim     = 32'd1 << lw;
    h_lim     = 32'd1 << lh;
    bad_mode  = (in_mode == PIX_BAD);
    bad_range = (in_x1 < in_x0) || (in_y1 < in_y0) ||
                (32'(in_x1) >= w_lim) || (32'(in_y1) >= h_lim);
    xo_c      = in_syx[0] ? reflect(32'(in_x1), lw) : 32'(in_x0);
    yo_c      = in_syx[1] ? reflect(32'(in_y1), lh) : 32'(in_y0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_err   <= 1'b0;
      s1_syx   <= '0;
      s1_mode  <= '0;
      s1_xo    <= '0;
      s1_yo    <= '0;
      s1_major <= '0;
      s1_minor <= '0;
      s1_shift <= '0;
    end else begin
      s1_valid <= in_valid;
      s1_err   <= bad_mode || bad_range;
      s1_syx   <= in_syx;
      s1_mode  <= in_mode;
      s1_xo    <= xo_c[CW-1:0];
      s1_yo    <= yo_c[CW-1:0];
      // transpose picks which coordinate is scaled by the line length
      s1_major <= in_syx[2] ? xo_c[CW-1:0] : yo_c[CW-1:0];
      s1_minor <= in_syx[2] ? yo_c[CW-1:0] : xo_c[CW-1:0];
      s1_shift <= in_syx[2] ? lh : lw;
    end
  end

  // R8: the unsupported mode is flagged one stage later
  p_bad_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode == 2'b11) |=> (s1_valid && s1_err));

  // R9: reversed corners are flagged one stage later
  p_reversed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_x1 < in_x0 || in_y1 < in_y0)) |=> s1_err);

endmodule

// File: rtl/ofb_compose.sv
module ofb_compose #(
  parameter int CW    = 14,
  parameter int OFS_W = 29
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s1_valid,
  input  logic             s1_err,
  input  logic [2:0]       s1_syx,
  input  logic [1:0]       s1_mode,
  input  logic [CW-1:0]    s1_xo,
  input  logic [CW-1:0]    s1_yo,
  input  logic [CW-1:0]    s1_major,
  input  logic [CW-1:0]    s1_minor,
  input  logic [5:0]       s1_shift,
  output logic             out_valid,
  output logic             out_err,
  output logic [CW-1:0]    out_x,
  output logic [CW-1:0]    out_y,
  output logic [OFS_W-1:0] out_offset,
  output logic [OFS_W+3:0] out_addr
);
  import ofb_pkg::*;

  localparam int BYTE_W = OFS_W - 2;

  logic [63:0]      bytes;
  logic [OFS_W-1:0] ofs_c;
  logic             byte_fits;

  always_comb begin
    bytes     = byte_index(32'(s1_major), 32'(s1_minor), s1_shift, s1_mode);
    ofs_c     = {s1_mode, bytes[BYTE_W-1:0]};
    byte_fits = (bytes >> BYTE_W) == 64'd0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_err    <= 1'b0;
      out_x      <= '0;
      out_y      <= '0;
      out_offset <= '0;
      out_addr   <= '0;
    end else begin
      out_valid  <= s1_valid && !s1_err;
      out_err    <= s1_valid && s1_err;
      out_x      <= s1_syx[2] ? s1_yo : s1_xo;
      out_y      <= s1_syx[2] ? s1_xo : s1_yo;
      out_offset <= ofs_c;
      out_addr   <= {1'b1, s1_syx, ofs_c};
    end
  end

  // R5: a legal request never spills into the mode bits
  p_byte_fits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && !s1_err) |-> byte_fits);

  // R6: the view bits reach the full address unchanged
  p_view_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && !s1_err) |=> (out_addr[OFS_W+2:OFS_W] == $past(s1_syx)));

endmodule

// File: rtl/ofb_addr_gen.sv
module ofb_addr_gen #(
  parameter int CW     = 14,
  parameter int LOG_W8 = 14,
  parameter int LOG_H8 = 13,
  parameter int OFS_W  = 29
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       in_mode,
  input  logic [2:0]       in_syx,
  input  logic [CW-1:0]    in_x0,
  input  logic [CW-1:0]    in_y0,
  input  logic [CW-1:0]    in_x1,
  input  logic [CW-1:0]    in_y1,
  output logic             out_valid,
  output logic             out_err,
  output logic [CW-1:0]    out_x,
  output logic [CW-1:0]    out_y,
  output logic [OFS_W-1:0] out_offset,
  output logic [OFS_W+3:0] out_addr
);

  logic          s1_valid, s1_err;
  logic [2:0]    s1_syx;
  logic [1:0]    s1_mode;
  logic [CW-1:0] s1_xo, s1_yo, s1_major, s1_minor;
  logic [5:0]    s1_shift;

  ofb_orient #(.CW(CW), .LOG_W8(LOG_W8), .LOG_H8(LOG_H8)) u_orient (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode), .in_syx(in_syx),
    .in_x0(in_x0), .in_y0(in_y0), .in_x1(in_x1), .in_y1(in_y1),
    .s1_valid(s1_valid), .s1_err(s1_err), .s1_syx(s1_syx), .s1_mode(s1_mode),
    .s1_xo(s1_xo), .s1_yo(s1_yo), .s1_major(s1_major), .s1_minor(s1_minor),
    .s1_shift(s1_shift)
  );

  ofb_compose #(.CW(CW), .OFS_W(OFS_W)) u_compose (
    .clk(clk), .rst_n(rst_n), .s1_valid(s1_valid), .s1_err(s1_err), .s1_syx(s1_syx),
    .s1_mode(s1_mode), .s1_xo(s1_xo), .s1_yo(s1_yo), .s1_major(s1_major),
    .s1_minor(s1_minor), .s1_shift(s1_shift),
    .out_valid(out_valid), .out_err(out_err), .out_x(out_x), .out_y(out_y),
    .out_offset(out_offset), .out_addr(out_addr)
  );

  // R8/R9: a request ends in a result or a rejection, never both
  p_one_outcome_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && out_err));

  // R10: every request surfaces exactly two cycles later
  p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid || out_err) == $past(in_valid, 2));

  // R6: a result always carries the marker bit and its own offset
  p_marker_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_addr[OFS_W+3] && out_addr[OFS_W-1:0] == out_offset));

  // R5: a result is aligned to its pixel size and never reports mode 11
  p_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_offset[OFS_W-1:OFS_W-2] != 2'b11 &&
                   (out_offset[1:0] & ((2'b01 << out_offset[OFS_W-1:OFS_W-2]) - 2'b01)) == 2'b00));

endmodule

// File: tb/tb_ofb_addr_gen.sv
module tb_ofb_addr_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [1:0]  in_mode;
  logic [2:0]  in_syx;
  logic [13:0] in_x0, in_y0, in_x1, in_y1;
  logic        out_valid, out_err;
  logic [13:0] out_x, out_y;
  logic [28:0] out_offset;
  logic [32:0] out_addr;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ofb_addr_gen dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode), .in_syx(in_syx),
    .in_x0(in_x0), .in_y0(in_y0), .in_x1(in_x1), .in_y1(in_y1),
    .out_valid(out_valid), .out_err(out_err), .out_x(out_x), .out_y(out_y),
    .out_offset(out_offset), .out_addr(out_addr)
  );

  // {syx, expected full address} for an 8-bit frame from (16,32) to (223,159)
  localparam logic [35:0] VEC [8] = '{
    {3'b000, 33'h1_0008_0010}, {3'b001, 33'h1_2008_3F20},
    {3'b010, 33'h1_47D8_0010}, {3'b011, 33'h1_67D8_3F20},
    {3'b100, 33'h1_8002_0020}, {3'b101, 33'h1_A7E4_0020},
    {3'b110, 33'h1_C002_1F60}, {3'b111, 33'h1_E7E4_1F60}
  };

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive one request, then wait until its result is on the outputs
  task automatic send(input logic [1:0] m, input logic [2:0] v,
                      input int x0, input int y0, input int x1, input int y1);
    @(negedge clk);
    in_valid = 1'b1; in_mode = m; in_syx = v;
    in_x0 = 14'(x0); in_y0 = 14'(y0); in_x1 = 14'(x1); in_y1 = 14'(y1);
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
  endtask

  // full model restated with real products
  function automatic longint model_addr(input int m, input int v, input int x0, input int y0,
                                        input int x1, input int y1, output int ex, output int ey);
    longint w, h, xo, yo, p, off;
    w  = (m == 2) ? 8192 : 16384;
    h  = (m == 0) ? 8192 : 4096;
    xo = v[0] ? (w - 1 - x1) : x0;
    yo = v[1] ? (h - 1 - y1) : y0;
    p  = v[2] ? (xo * h + yo) : (yo * w + xo);
    off = p * (64'd1 << m) + longint'(m) * 134217728;
    ex = int'(v[2] ? yo : xo);
    ey = int'(v[2] ? xo : yo);
    return 64'h1_0000_0000 + longint'(v) * 536870912 + off;
  endfunction

  task automatic model_check(input int m, input int v, input int x0, input int y0,
                             input int x1, input int y1, input string tag);
    longint ea; int ex, ey;
    ea = model_addr(m, v, x0, y0, x1, y1, ex, ey);
    send(2'(m), 3'(v), x0, y0, x1, y1);
    check(out_valid && !out_err, {tag, " R10 valid"}, {out_valid, out_err}, 2'b10);
    check(out_addr == 33'(ea), {tag, " R3/R4/R6 address"}, out_addr, ea);
    check(out_offset == 29'(ea), {tag, " R5 offset"}, out_offset, ea & 64'h1FFF_FFFF);
    check(out_x == 14'(ex) && out_y == 14'(ey), {tag, " R7 coords"}, {out_x, out_y}, {14'(ex), 14'(ey)});
  endtask

  task automatic reject_check(input int m, input int v, input int x0, input int y0,
                              input int x1, input int y1, input string tag);
    send(2'(m), 3'(v), x0, y0, x1, y1);
    check(!out_valid && out_err, tag, {out_valid, out_err}, 2'b01);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_mode = 2'b00; in_syx = 3'b000;
    in_x0 = '0; in_y0 = '0; in_x1 = '0; in_y1 = '0;
    repeat (3) @(negedge clk);
    check(!out_valid && !out_err && out_addr == 33'd0, "reset state R10",
          {out_valid, out_err, out_addr}, 35'd0);
    rst_n = 1'b1;

    // table walk: the eight views of one 8-bit frame (R1 R2 R3 R4 R6 R7)
    for (int i = 0; i < 8; i++) begin
      logic [2:0] v;
      int ex, ey, xo, yo;
      v  = VEC[i][35:33];
      xo = v[0] ? 16160 : 16;
      yo = v[1] ? 8032 : 32;
      ex = v[2] ? yo : xo;
      ey = v[2] ? xo : yo;
      send(2'b00, v, 16, 32, 223, 159);
      check(out_valid, "R10 table valid", out_valid, 1);
      check(out_addr == VEC[i][32:0], "R1/R2/R3/R4/R6 table address", out_addr, VEC[i][32:0]);
      check(out_offset[28:27] == 2'b00, "R5 8-bit mode bits", out_offset[28:27], 0);
      check(out_x == 14'(ex) && out_y == 14'(ey), "R7 table coords", {out_x, out_y}, {14'(ex), 14'(ey)});
    end

    // 16-bit and 32-bit containers, every view (R5)
    for (int v = 0; v < 8; v++) begin
      model_check(1, v, 10, 5, 100, 50, "mode01");
      model_check(2, v, 7, 9, 8191, 4095, "mode10 far edge");
    end
    model_check(0, 3, 0, 0, 16383, 8191, "mode00 whole container");

    // rejections
    reject_check(3, 0, 1, 1, 2, 2, "R8 mode 11 rejected");
    reject_check(0, 0, 50, 1, 40, 2, "R9 x1<x0");
    reject_check(0, 5, 1, 50, 2, 40, "R9 y1<y0");
    reject_check(1, 0, 0, 0, 10, 4096, "R9 y1>=H 16-bit");
    reject_check(2, 0, 0, 0, 8192, 10, "R9 x1>=W 32-bit");

    // back-to-back requests keep their order (R10)
    @(negedge clk);
    in_valid = 1'b1; in_mode = 2'b00; in_syx = 3'b000;
    in_x0 = 14'd1; in_y0 = 14'd2; in_x1 = 14'd3; in_y1 = 14'd4;
    @(negedge clk);
    in_syx = 3'b100;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && out_addr == 33'h1_0000_8001, "R10 first of pair", out_addr, 33'h1_0000_8001);
    @(negedge clk);
    check(out_valid && out_addr == 33'h1_8000_2002, "R10 second of pair", out_addr, 33'h1_8000_2002);

    // no request, no strobe (R10)
    in_mode = 2'b11; in_x1 = 14'd0;
    repeat (3) @(negedge clk);
    check(!out_valid && !out_err, "R10 idle no strobe", {out_valid, out_err}, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule